// File: doc/BRIEF.md
# Lockable Backup Register RAM

This block is a small byte-wide storage array of the kind kept alive by a backup supply next to a real-time clock. Software reaches it through a single address/data port with separate write and read strobes, and read data comes back from a register one cycle after the read strobe. Two fixed windows of eight bytes inside the array can each be sealed by its own protection bit. The protection bits are written through a separate configuration port.

While a window is sealed, writes that land in it are dropped and reads from it return a fixed filler byte instead of the stored contents. A protection bit can only be set. Writing zero to it, or writing it again, has no effect. Only the hard reset clears the protection bits. The array contents survive hard reset and are wiped only by a separate backup-loss reset. After a hard reset, firmware can seal the windows again with a new configuration write.

Top module: `lockable_backup_ram`

## Requirements
- R1: While hard reset is asserted and after it is released, `lock_status` reads 2'b00 and `rd_data` reads 8'h00 until the first read.
- R2: A read strobe at one rising edge makes `rd_data` show the addressed byte after that edge. `rd_data` keeps its value in every cycle without a read strobe.
- R3: A write strobe to an address outside any sealed window stores `wr_data`, and a later read of that address returns it.
- R4: A write strobe to an address inside a sealed window leaves the stored byte unchanged. The old byte is seen again once a hard reset has unsealed the window.
- R5: A read strobe to an address inside a sealed window returns the filler byte 8'hFF on `rd_data`.
- R6: `cfg_lock_data` bit 0 seals window 0 (default addresses 0x38 to 0x3F) and bit 1 seals window 1 (default 0x78 to 0x7F) when `cfg_lock_wr` is high. A 0 bit never clears a seal. `lock_status` reports the two seal bits in the same positions.
- R7: Hard reset clears both seal bits and keeps the array contents. The windows can be sealed again by a later configuration write.
- R8: Backup-loss reset clears every array byte to 8'h00 and does not change the seal bits.
- R9: Sealing one window changes neither reads nor writes of the other window nor of addresses outside both windows.
- R10: A read and a write to the same address in the same cycle return the byte held before the write. A seal written in a cycle first gates accesses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset; clears seal bits and read register |
| backup_rst_n | input | 1 | Asynchronous active-low backup-loss reset; clears the array |
| acc_addr | input | 7 | Byte address for reads and writes |
| wr_data | input | 8 | Byte to be written |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| cfg_lock_wr | input | 1 | Configuration write strobe for the seal bits |
| cfg_lock_data | input | 2 | Seal bits to set, one per window |
| lock_status | output | 2 | Current seal bits |

## Verification
A seal bit that is wrongly cleared shows up on the first read of its window, which returns the true byte instead of 8'hFF one cycle after the strobe. A seal bit that is wrongly set shows the same way on the window that should be open. A write that slips through a seal is hidden until the next hard reset. The bench therefore always reads the sealed bytes back after unsealing, and a corrupted byte shows at that read. An error in the read register or in window decode shows on the read one cycle after the strobe. The bench exercises window edges and the addresses next to them for this reason.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

   localparam int unsigned NUM_WINDOWS = 2;

   typedef logic [NUM_WINDOWS-1:0] seal_vec_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/lbr_seal_regs.sv
module lbr_seal_regs
   import lbr_pkg::*;
(
   input  logic      clk,
   input  logic      hard_rst_n,
   input  logic      cfg_wr,
   input  seal_vec_t cfg_bits,
   output seal_vec_t seal_q
);

   seal_vec_t set_req;

   assign set_req = cfg_wr ? cfg_bits : '0;

   for (genvar w = 0; w < NUM_WINDOWS; w++) begin : g_seal
      always_ff @(posedge clk or negedge hard_rst_n) begin
         if (!hard_rst_n)
            seal_q[w] <= 1'b0;
         else if (set_req[w])
            seal_q[w] <= 1'b1;
      end

      assert_seal_sticky_R6 : assert property (@(posedge clk) disable iff (!hard_rst_n)
         seal_q[w] |=> seal_q[w]);

      assert_seal_takes_R6 : assert property (@(posedge clk) disable iff (!hard_rst_n)
         (cfg_wr && cfg_bits[w]) |=> seal_q[w]);
   end

endmodule

// File: rtl/lbr_window_decode.sv
module lbr_window_decode
   import lbr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 7,
   parameter int unsigned WINDOW_BYTES = 8,
   parameter logic [NUM_WINDOWS-1:0][ADDR_W-1:0] BASES = '0
) (
   input  logic [ADDR_W-1:0] addr,
   input  seal_vec_t         seal,
   output seal_vec_t         hit,
   output logic              blocked
);

   localparam int unsigned         OFS_W    = $clog2(WINDOW_BYTES);
   localparam logic [ADDR_W-1:0]   TAG_MASK = ~ADDR_W'((1 << OFS_W) - 1);

   for (genvar w = 0; w < NUM_WINDOWS; w++) begin : g_win
      localparam logic [ADDR_W-1:0] TAG = BASES[w] & TAG_MASK;
      assign hit[w] = ((addr & TAG_MASK) == TAG);
   end

   assign blocked = |(hit & seal);

   always_comb begin
      assert_hits_disjoint_R9 : assert ($onehot0(hit));
   end

endmodule

// File: rtl/lbr_storage.sv
module lbr_storage #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] FILL = '1
) (
   input  logic              clk,
   input  logic              hard_rst_n,
   input  logic              backup_rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              blocked,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] cur_word;
   logic              wr_ok;

   assign cur_word = mem[addr];
   assign wr_ok    = wr_en && !blocked;

   always_ff @(posedge clk or negedge backup_rst_n) begin
      if (!backup_rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            mem[i] <= '0;
      end else if (wr_ok) begin
         mem[addr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge hard_rst_n) begin
      if (!hard_rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= blocked ? FILL : cur_word;
   end

   // checker state: remembers a dropped write so the next edge can compare
   logic              chk_rst_n;
   logic              chk_armed;
   logic [ADDR_W-1:0] chk_addr;
   logic [DATA_W-1:0] chk_word;

   assign chk_rst_n = hard_rst_n & backup_rst_n;

   always_ff @(posedge clk or negedge chk_rst_n) begin
      if (!chk_rst_n) begin
         chk_armed <= 1'b0;
         chk_addr  <= '0;
         chk_word  <= '0;
      end else begin
         chk_armed <= wr_en && blocked;
         chk_addr  <= addr;
         chk_word  <= cur_word;
      end
   end

   assert_sealed_write_dropped_R4 : assert property (@(posedge clk)
      disable iff (!hard_rst_n || !backup_rst_n)
      chk_armed |-> (mem[chk_addr] == chk_word));

   assert_sealed_read_fill_R5 : assert property (@(posedge clk) disable iff (!hard_rst_n)
      (rd_en && blocked) |=> (rdata == FILL));

   assert_rdata_hold_R2 : assert property (@(posedge clk) disable iff (!hard_rst_n)
      !rd_en |=> $stable(rdata));

endmodule

// File: rtl/lockable_backup_ram.sv
module lockable_backup_ram
   import lbr_pkg::*;
#(
   parameter int unsigned ADDR_W       = 7,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned WINDOW_BYTES = 8,
   parameter int unsigned WINDOW0_BASE = 56,
   parameter int unsigned WINDOW1_BASE = 120,
   parameter logic [DATA_W-1:0] FILL   = '1
) (
   input  logic                   clk,
   input  logic                   hard_rst_n,
   input  logic                   backup_rst_n,
   input  logic [ADDR_W-1:0]      acc_addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   wr_en,
   input  logic                   rd_en,
   output logic [DATA_W-1:0]      rd_data,
   input  logic                   cfg_lock_wr,
   input  logic [NUM_WINDOWS-1:0] cfg_lock_data,
   output logic [NUM_WINDOWS-1:0] lock_status
);

   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam logic [NUM_WINDOWS-1:0][ADDR_W-1:0] BASES =
      {ADDR_W'(WINDOW1_BASE), ADDR_W'(WINDOW0_BASE)};

   if (!is_pow2(WINDOW_BYTES) || WINDOW_BYTES > DEPTH) begin : g_bad_size
      $error("window size must be a power of two no larger than the array");
   end
   if ((WINDOW0_BASE % WINDOW_BYTES) != 0 || (WINDOW1_BASE % WINDOW_BYTES) != 0) begin : g_bad_align
      $error("window bases must be aligned to the window size");
   end
   if (WINDOW0_BASE >= DEPTH || WINDOW1_BASE >= DEPTH) begin : g_bad_range
      $error("window bases must lie inside the array");
   end
   if (WINDOW0_BASE == WINDOW1_BASE) begin : g_bad_overlap
      $error("windows must not overlap");
   end

   seal_vec_t seal_q;
   seal_vec_t win_hit;
   logic      acc_blocked;

   lbr_seal_regs i_seal (
      .clk        (clk),
      .hard_rst_n (hard_rst_n),
      .cfg_wr     (cfg_lock_wr),
      .cfg_bits   (cfg_lock_data),
      .seal_q     (seal_q)
   );

   lbr_window_decode #(
      .ADDR_W       (ADDR_W),
      .WINDOW_BYTES (WINDOW_BYTES),
      .BASES        (BASES)
   ) i_decode (
      .addr    (acc_addr),
      .seal    (seal_q),
      .hit     (win_hit),
      .blocked (acc_blocked)
   );

   lbr_storage #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .FILL   (FILL)
   ) i_store (
      .clk          (clk),
      .hard_rst_n   (hard_rst_n),
      .backup_rst_n (backup_rst_n),
      .addr         (acc_addr),
      .wdata        (wr_data),
      .wr_en        (wr_en),
      .rd_en        (rd_en),
      .blocked      (acc_blocked),
      .rdata        (rd_data)
   );

   assign lock_status = seal_q;

endmodule

// File: tb/test_lockable_backup_ram.sv
module test_lockable_backup_ram;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       hard_rst_n = 1'b0;
   logic       backup_rst_n = 1'b0;
   logic [6:0] acc_addr = '0;
   logic [7:0] wr_data = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       cfg_lock_wr = 1'b0;
   logic [1:0] cfg_lock_data = '0;
   logic [1:0] lock_status;

   int n_checks = 0;
   int n_fails  = 0;

   logic [7:0] model_mem [128];
   logic [1:0] model_seal = '0;
   logic [7:0] model_rd   = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lockable_backup_ram i_lockable_backup_ram (
      .clk           (clk),
      .hard_rst_n    (hard_rst_n),
      .backup_rst_n  (backup_rst_n),
      .acc_addr      (acc_addr),
      .wr_data       (wr_data),
      .wr_en         (wr_en),
      .rd_en         (rd_en),
      .rd_data       (rd_data),
      .cfg_lock_wr   (cfg_lock_wr),
      .cfg_lock_data (cfg_lock_data),
      .lock_status   (lock_status)
   );

   function automatic bit sealed(input logic [6:0] a, input logic [1:0] s);
      return (s[0] && a[6:3] == 4'd7) || (s[1] && a[6:3] == 4'd15);
   endfunction

   function automatic logic [7:0] expect_read(input logic [6:0] a);
      return sealed(a, model_seal) ? 8'hFF : model_mem[a];
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one bus cycle, entered and left at a falling edge
   task automatic cycle(input bit w, input bit r, input logic [6:0] a, input logic [7:0] d,
                        input bit c, input logic [1:0] cd, input string req);
      logic [7:0] exp;
      bit         blk;
      acc_addr = a; wr_data = d; wr_en = w; rd_en = r;
      cfg_lock_wr = c; cfg_lock_data = cd;
      exp = expect_read(a);
      blk = sealed(a, model_seal);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; cfg_lock_wr = 1'b0; cfg_lock_data = '0;
      if (r) model_rd = exp;
      if (w && !blk) model_mem[a] = d;
      if (c) model_seal = model_seal | cd;
      check(req, rd_data, model_rd);
   endtask

   task automatic seal_cfg(input logic [1:0] cd);
      cycle(1'b0, 1'b0, 7'd0, 8'd0, 1'b1, cd, "R6");
      check("R6 lock_status", {6'd0, lock_status}, {6'd0, model_seal});
   endtask

   task automatic pulse_hard_reset();
      hard_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 lock_status in reset", {6'd0, lock_status}, 8'h00);
      check("R1 rd_data in reset", rd_data, 8'h00);
      hard_rst_n = 1'b1;
      model_seal = '0;
      model_rd = '0;
      @(negedge clk);
   endtask

   task automatic random_ops(input int n, input string req);
      for (int k = 0; k < n; k++) begin
         int unsigned kind = $urandom % 4;
         logic [6:0] a = 7'($urandom);
         logic [7:0] d = 8'($urandom);
         if ($urandom % 3 == 0) a = {($urandom % 2) ? 4'd15 : 4'd7, 3'($urandom)};
         case (kind)
            0: cycle(1'b1, 1'b0, a, d, 1'b0, 2'b00, req);
            1: cycle(1'b0, 1'b1, a, d, 1'b0, 2'b00, req);
            2: cycle(1'b1, 1'b1, a, d, 1'b0, 2'b00, "R10");
            default: cycle(1'b0, 1'b0, a, d, 1'b0, 2'b00, "R2 hold");
         endcase
      end
   endtask

   initial begin
      for (int i = 0; i < 128; i++) model_mem[i] = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 lock_status", {6'd0, lock_status}, 8'h00);
      check("R1 rd_data", rd_data, 8'h00);
      backup_rst_n = 1'b1;
      hard_rst_n = 1'b1;
      @(negedge clk);

      // R8: array starts cleared by backup-loss reset
      cycle(1'b0, 1'b1, 7'd5, 8'd0, 1'b0, 2'b00, "R8");
      // R3 / R2: fill every byte with a distinct non-filler value
      for (int i = 0; i < 128; i++)
         cycle(1'b1, 1'b0, 7'(i), 8'(i * 3 + 1) & 8'h7F, 1'b0, 2'b00, "R3");
      cycle(1'b0, 1'b1, 7'h38, 8'd0, 1'b0, 2'b00, "R3");
      cycle(1'b0, 1'b0, 7'h10, 8'd0, 1'b0, 2'b00, "R2 hold");
      cycle(1'b0, 1'b1, 7'h7F, 8'd0, 1'b0, 2'b00, "R2");
      random_ops(300, "R3");

      // R10: same-cycle read and write see the old byte
      cycle(1'b1, 1'b1, 7'h22, 8'hA5, 1'b0, 2'b00, "R10");
      cycle(1'b0, 1'b1, 7'h22, 8'h00, 1'b0, 2'b00, "R10");

      // R6 / R5 / R9: seal window 0
      seal_cfg(2'b01);
      cycle(1'b0, 1'b1, 7'h38, 8'd0, 1'b0, 2'b00, "R5");
      cycle(1'b0, 1'b1, 7'h3F, 8'd0, 1'b0, 2'b00, "R5");
      cycle(1'b0, 1'b1, 7'h37, 8'd0, 1'b0, 2'b00, "R9");
      cycle(1'b0, 1'b1, 7'h40, 8'd0, 1'b0, 2'b00, "R9");
      cycle(1'b1, 1'b0, 7'h3A, 8'h11, 1'b0, 2'b00, "R4");
      cycle(1'b1, 1'b0, 7'h7A, 8'h5C, 1'b0, 2'b00, "R9");
      cycle(1'b0, 1'b1, 7'h7A, 8'd0, 1'b0, 2'b00, "R9");
      seal_cfg(2'b00);
      seal_cfg(2'b01);
      cycle(1'b0, 1'b1, 7'h3C, 8'd0, 1'b0, 2'b00, "R6");

      // R10: seal and write in the same cycle; write still lands
      cycle(1'b1, 1'b0, 7'h79, 8'h6E, 1'b1, 2'b10, "R10");
      check("R6 lock_status both", {6'd0, lock_status}, 8'h03);
      cycle(1'b1, 1'b0, 7'h79, 8'h01, 1'b0, 2'b00, "R4");
      cycle(1'b0, 1'b1, 7'h79, 8'd0, 1'b0, 2'b00, "R5");
      random_ops(300, "R4");

      // R7: hard reset unseals and keeps contents, then relock
      pulse_hard_reset();
      check("R7 lock_status", {6'd0, lock_status}, 8'h00);
      cycle(1'b0, 1'b1, 7'h79, 8'd0, 1'b0, 2'b00, "R7");
      cycle(1'b0, 1'b1, 7'h3A, 8'd0, 1'b0, 2'b00, "R4");
      for (int i = 56; i < 64; i++)
         cycle(1'b0, 1'b1, 7'(i), 8'd0, 1'b0, 2'b00, "R4");
      for (int i = 120; i < 128; i++)
         cycle(1'b0, 1'b1, 7'(i), 8'd0, 1'b0, 2'b00, "R4");
      seal_cfg(2'b10);
      cycle(1'b0, 1'b1, 7'h78, 8'd0, 1'b0, 2'b00, "R7");
      cycle(1'b0, 1'b1, 7'h38, 8'd0, 1'b0, 2'b00, "R9");
      random_ops(200, "R9");

      // R8: backup-loss reset clears the array, seal bits stay
      backup_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      backup_rst_n = 1'b1;
      for (int i = 0; i < 128; i++) model_mem[i] = '0;
      @(negedge clk);
      check("R8 lock_status kept", {6'd0, lock_status}, 8'h02);
      cycle(1'b0, 1'b1, 7'h22, 8'd0, 1'b0, 2'b00, "R8");
      cycle(1'b0, 1'b1, 7'h7D, 8'd0, 1'b0, 2'b00, "R8");
      pulse_hard_reset();
      cycle(1'b0, 1'b1, 7'h7D, 8'd0, 1'b0, 2'b00, "R8");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule